// File: doc/BRIEF.md
# Read Output Path with Selectable Flow-Through or Pipelined Latency

This block sits between the sense outputs of a synchronous 32-bit memory array and the shared data bus. It produces the data word that the bus should carry and a drive-enable flag that controls the bus tri-state drivers. A static mode input selects the read latency. In flow-through mode, the word read in a cycle is presented within that same cycle. In pipelined mode, the word passes through an output register and is presented one clock later.

A companion controller classifies every clock cycle as a hold (no new access), a read, a write or a deselect. For each cycle the controller supplies:

- the array's read word;
- the data and byte mask written in the previous cycle;
- a flag that marks the current read as targeting the word that was just written.

The path merges freshly written bytes over the array word. A read that directly follows a write therefore returns the new data, and a hold after a write shows the just-written bytes.

An active-low output enable gates the bus drive without waiting for a clock edge. Writes, deselects and reset all keep the bus released.

Top module: `opath_rd_out`

## Requirements
- R1: While rst_n is low, dq_oe is 0 and dq_out is 0 in every cycle type and mode.
- R2: With pipe_mode = 0, a read cycle (cyc = 2'b01) with oe_n low drives dq_oe = 1 and shows the merged read word on dq_out in that same cycle.
- R3: With pipe_mode = 1, the merged word of a read cycle appears on dq_out in the next cycle (dq_oe = 1 when that cycle is a hold or read and oe_n is low). It is not shown in the read cycle itself when the previous cycle was a deselect.
- R4: oe_n high forces dq_oe = 0 and dq_out = 0 at once, without a clock edge. Lowering oe_n restores the drive within the same cycle.
- R5: In a read with fwd_hit = 1, byte b of the word is taken from wr_data_prev when wr_bmask_prev[b] is 1, and from arr_rdata otherwise. Byte b occupies bits 8b+7 down to 8b.
- R6: A hold cycle (cyc = 2'b00) that follows a write shows the bytes marked in wr_bmask_prev from wr_data_prev, with fwd_hit ignored. With pipe_mode = 1 this word appears one cycle later. With oe_n high the bus stays released.
- R7: A deselect cycle (cyc = 2'b11) gives dq_oe = 0 in that cycle in both modes, even after a pipelined read. Following hold cycles keep dq_oe = 0 until the next read.
- R8: During a write cycle (cyc = 2'b10), dq_oe is 0 in both modes.
- R9: A suspended burst, a read repeated at an unadvanced address, keeps presenting that address's word every cycle. In pipelined mode the word is presented with one cycle of offset.
- R10: With fwd_hit = 0, a read shows arr_rdata unchanged, whatever wr_bmask_prev holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 = pipelined output, 0 = flow-through |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cyc | input | 2 | Cycle type: 00 hold, 01 read, 10 write, 11 deselect |
| arr_rdata | input | 32 | Array read word for the current address |
| wr_data_prev | input | 32 | Data written in the previous cycle |
| wr_bmask_prev | input | 4 | Byte mask of the previous cycle's write (bit b = byte b) |
| fwd_hit | input | 1 | Current read address equals the previous write address |
| dq_out | output | 32 | Data to drive onto the bus (0 when not driven) |
| dq_oe | output | 1 | Bus drive enable |

## Verification
In flow-through mode, every result is due in the cycle of its stimulus. The bench therefore drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. In pipelined mode, a read's word is registered at the next rising edge and is due in the following cycle. The bench checks that word one cycle later, after the next falling-edge drive. It also checks that the word is absent in the read cycle itself. The output-enable checks toggle oe_n with no clock edge in between, which confirms that the gating takes effect at once.

// File: rtl/opath_pkg.sv
package opath_pkg;
  typedef enum logic [1:0] {
    CY_HOLD  = 2'b00,
    CY_READ  = 2'b01,
    CY_WRITE = 2'b10,
    CY_DESEL = 2'b11
  } cyc_e;
endpackage

// File: rtl/opath_merge.sv
module opath_merge #(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int NB = DW / BW
) (
  input  logic [DW-1:0] arr_word,
  input  logic [DW-1:0] fwd_word,
  input  logic [NB-1:0] fwd_mask,
  input  logic          fwd_en,
  output logic [DW-1:0] merged
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_comb begin
      if (fwd_en && fwd_mask[b]) merged[b*BW +: BW] = fwd_word[b*BW +: BW];
      else                       merged[b*BW +: BW] = arr_word[b*BW +: BW];
    end
  end
endmodule

// File: rtl/opath_sel_track.sv
module opath_sel_track
  import opath_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cyc_e cyc,
  output logic sel_q
);
  logic sel_d;
  logic sel_en;

  always_comb begin
    sel_en = (cyc != CY_HOLD);
    sel_d  = (cyc == CY_READ) || (cyc == CY_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_en) sel_q <= sel_d;
  end
endmodule

// File: rtl/opath_pipe_stage.sv
module opath_pipe_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  output logic          vld_q,
  output logic [DW-1:0] data_q
);
  logic          vld_d;
  logic [DW-1:0] data_d;
  logic          data_en;

  always_comb begin
    vld_d   = in_vld;
    data_en = in_vld;
    data_d  = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end
endmodule

// File: rtl/opath_rd_out.sv
module opath_rd_out
  import opath_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int NB = DW / BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic          oe_n,
  input  logic [1:0]    cyc,
  input  logic [DW-1:0] arr_rdata,
  input  logic [DW-1:0] wr_data_prev,
  input  logic [NB-1:0] wr_bmask_prev,
  input  logic          fwd_hit,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  cyc_e          cyc_t;
  logic          sel_q;
  logic          fwd_en;
  logic [DW-1:0] merged;
  logic          ft_vld;
  logic          pq_vld;
  logic [DW-1:0] pq_data;
  logic          blocked;
  logic          src_vld;
  logic [DW-1:0] src_data;

  assign cyc_t = cyc_e'(cyc);

  opath_sel_track u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .cyc   (cyc_t),
    .sel_q (sel_q)
  );

  always_comb begin
    fwd_en = (cyc_t == CY_HOLD) ? 1'b1 : fwd_hit;
    ft_vld = (cyc_t == CY_READ) || ((cyc_t == CY_HOLD) && sel_q);
  end

  opath_merge #(.DW(DW), .BW(BW)) u_merge (
    .arr_word (arr_rdata),
    .fwd_word (wr_data_prev),
    .fwd_mask (wr_bmask_prev),
    .fwd_en   (fwd_en),
    .merged   (merged)
  );

  opath_pipe_stage #(.DW(DW)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (ft_vld),
    .in_data (merged),
    .vld_q   (pq_vld),
    .data_q  (pq_data)
  );

  always_comb begin
    blocked = (cyc_t == CY_WRITE) || (cyc_t == CY_DESEL) || oe_n || !rst_n;
    if (pipe_mode) begin
      src_vld  = pq_vld;
      src_data = pq_data;
    end else begin
      src_vld  = ft_vld;
      src_data = merged;
    end
    dq_oe  = src_vld && !blocked;
    dq_out = dq_oe ? src_data : '0;
  end
endmodule

// File: rtl/opath_rd_out_chk.sv
module opath_rd_out_chk #(
  parameter int DW = 32,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pipe_mode,
  input logic          oe_n,
  input logic [1:0]    cyc,
  input logic [DW-1:0] arr_rdata,
  input logic [DW-1:0] wr_data_prev,
  input logic [NB-1:0] wr_bmask_prev,
  input logic          fwd_hit,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);
  // R1: released during reset
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!dq_oe);
  end

  // R4: output enable gates the bus
  a_r4_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_oe && dq_out == '0));

  // R8: no drive during writes
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b10) |-> !dq_oe);

  // R7: no drive during deselect
  a_r7_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'b11) |-> !dq_oe);

  // R2 and R10: flow-through read without forwarding shows the array word
  a_r2_flow_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && cyc == 2'b01 && !fwd_hit && !oe_n) |->
      (dq_oe && dq_out == arr_rdata));

  // R3: pipelined read word shows one cycle later
  a_r3_pipe_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && pipe_mode && $past(pipe_mode) && $past(cyc) == 2'b01 &&
     !$past(fwd_hit) && cyc == 2'b00 && !oe_n) |->
      (dq_oe && dq_out == $past(arr_rdata)));
endmodule

bind opath_rd_out opath_rd_out_chk #(.DW(DW), .NB(NB)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pipe_mode     (pipe_mode),
  .oe_n          (oe_n),
  .cyc           (cyc),
  .arr_rdata     (arr_rdata),
  .wr_data_prev  (wr_data_prev),
  .wr_bmask_prev (wr_bmask_prev),
  .fwd_hit       (fwd_hit),
  .dq_out        (dq_out),
  .dq_oe         (dq_oe)
);

// File: tb/opath_rd_out_test.sv
`timescale 1ns/1ps
module opath_rd_out_test;
  localparam logic [1:0] HOLD = 2'b00, RD = 2'b01, WR = 2'b10, DS = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pipe_mode;
  logic        oe_n;
  logic [1:0]  cyc;
  logic [31:0] arr_rdata;
  logic [31:0] wr_data_prev;
  logic [3:0]  wr_bmask_prev;
  logic        fwd_hit;
  logic [31:0] dq_out;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  opath_rd_out uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe_n(oe_n), .cyc(cyc),
    .arr_rdata(arr_rdata), .wr_data_prev(wr_data_prev),
    .wr_bmask_prev(wr_bmask_prev), .fwd_hit(fwd_hit),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [31:0] expect_merge(input logic [31:0] a,
      input logic [31:0] w, input logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = m[b] ? w[b*8 +: 8] : a[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic oe_exp, input logic [31:0] d_exp);
    checks++;
    if (dq_oe !== oe_exp || dq_out !== d_exp) begin
      errors++;
      $display("FAIL %s: dq_oe=%0b dq_out=%08h expected dq_oe=%0b dq_out=%08h",
               req, dq_oe, dq_out, oe_exp, d_exp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [31:0] a,
      input logic [31:0] w, input logic [3:0] m, input logic h);
    @(negedge clk);
    cyc = c; arr_rdata = a; wr_data_prev = w; wr_bmask_prev = m; fwd_hit = h;
    #1;
  endtask

  task automatic t_reset;
    pipe_mode = 1'b0; oe_n = 1'b0; rst_n = 1'b0;
    step(RD, 32'hDEAD_BEEF, '0, '0, 1'b0);
    chk("R1 flow read in reset", 1'b0, 32'h0);
    pipe_mode = 1'b1;
    step(HOLD, 32'h1234_5678, '0, '0, 1'b0);
    chk("R1 pipe in reset", 1'b0, 32'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_flow_read;
    pipe_mode = 1'b0; oe_n = 1'b0;
    step(DS, '0, '0, '0, 1'b0);
    step(RD, 32'hA5A5_0001, '0, '0, 1'b0);
    chk("R2 flow read same cycle", 1'b1, 32'hA5A5_0001);
    step(RD, 32'hA5A5_0001, '0, '0, 1'b0);
    chk("R9 flow suspend repeat", 1'b1, 32'hA5A5_0001);
    step(HOLD, 32'hA5A5_0001, '0, '0, 1'b0);
    chk("R9 flow hold keeps word", 1'b1, 32'hA5A5_0001);
  endtask

  task automatic t_pipe_read;
    pipe_mode = 1'b1; oe_n = 1'b0;
    step(DS, '0, '0, '0, 1'b0);
    step(RD, 32'h0BAD_F00D, '0, '0, 1'b0);
    chk("R3 pipe not in read cycle", 1'b0, 32'h0);
    step(RD, 32'h0BAD_F00D, '0, '0, 1'b0);
    chk("R3 pipe one cycle later", 1'b1, 32'h0BAD_F00D);
    step(RD, 32'h0BAD_F00D, '0, '0, 1'b0);
    chk("R9 pipe suspend repeat", 1'b1, 32'h0BAD_F00D);
    step(RD, 32'h7777_1111, '0, '0, 1'b0);
    chk("R9 pipe still old word", 1'b1, 32'h0BAD_F00D);
    step(HOLD, 32'h7777_1111, '0, '0, 1'b0);
    chk("R3 pipe next word", 1'b1, 32'h7777_1111);
  endtask

  task automatic t_oe;
    pipe_mode = 1'b0; oe_n = 1'b1;
    step(RD, 32'h4242_4242, '0, '0, 1'b0);
    chk("R4 oe_n high releases", 1'b0, 32'h0);
    oe_n = 1'b0; #0.5;
    chk("R4 oe_n low restores unclocked", 1'b1, 32'h4242_4242);
    oe_n = 1'b1; #0.5;
    chk("R4 oe_n high again unclocked", 1'b0, 32'h0);
    oe_n = 1'b0;
  endtask

  task automatic t_forward;
    pipe_mode = 1'b0; oe_n = 1'b0;
    step(WR, 32'h9999_9999, '0, '0, 1'b0);
    chk("R8 flow write quiet", 1'b0, 32'h0);
    step(RD, 32'h1122_3344, 32'hAABB_CCDD, 4'b0100, 1'b1);
    chk("R5 one byte forwarded", 1'b1, expect_merge(32'h1122_3344, 32'hAABB_CCDD, 4'b0100));
    step(WR, 32'h0, '0, '0, 1'b0);
    step(RD, 32'h1122_3344, 32'hAABB_CCDD, 4'b1111, 1'b1);
    chk("R5 all bytes forwarded", 1'b1, 32'hAABB_CCDD);
    step(RD, 32'h5566_7788, 32'hAABB_CCDD, 4'b1111, 1'b0);
    chk("R10 no hit no forward", 1'b1, 32'h5566_7788);
    pipe_mode = 1'b1;
    step(WR, 32'h0, '0, '0, 1'b0);
    chk("R8 pipe write quiet after read", 1'b0, 32'h0);
  endtask

  task automatic t_hold_after_write;
    pipe_mode = 1'b0; oe_n = 1'b0;
    step(WR, 32'h0, '0, '0, 1'b0);
    step(HOLD, 32'h0000_0000, 32'hCAFE_1234, 4'b0001, 1'b0);
    chk("R6 flow hold one byte", 1'b1, 32'h0000_0034);
    step(WR, 32'h0, '0, '0, 1'b0);
    oe_n = 1'b1;
    step(HOLD, 32'h0, 32'hCAFE_1234, 4'b1111, 1'b0);
    chk("R6 hold with oe_n high", 1'b0, 32'h0);
    oe_n = 1'b0;
    pipe_mode = 1'b1;
    step(WR, 32'h0, '0, '0, 1'b0);
    step(HOLD, 32'h0000_0000, 32'hFEED_5A5A, 4'b1111, 1'b0);
    chk("R6 pipe hold not yet", 1'b0, 32'h0);
    step(HOLD, 32'hFEED_5A5A, '0, '0, 1'b0);
    chk("R6 pipe hold one later", 1'b1, 32'hFEED_5A5A);
  endtask

  task automatic t_desel;
    pipe_mode = 1'b1; oe_n = 1'b0;
    step(RD, 32'h3131_3131, '0, '0, 1'b0);
    step(DS, 32'h3131_3131, '0, '0, 1'b0);
    chk("R7 pipe deselect after read", 1'b0, 32'h0);
    step(HOLD, 32'h3131_3131, '0, '0, 1'b0);
    chk("R7 pipe hold after deselect", 1'b0, 32'h0);
    pipe_mode = 1'b0;
    step(RD, 32'h6262_6262, '0, '0, 1'b0);
    step(DS, 32'h6262_6262, '0, '0, 1'b0);
    chk("R7 flow deselect", 1'b0, 32'h0);
    step(HOLD, 32'h6262_6262, '0, '0, 1'b0);
    chk("R7 flow hold after deselect", 1'b0, 32'h0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected end of tests");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc = HOLD; arr_rdata = '0; wr_data_prev = '0; wr_bmask_prev = '0;
    fwd_hit = 1'b0; oe_n = 1'b1; pipe_mode = 1'b0; rst_n = 1'b0;
    t_reset();
    t_flow_read();
    t_pipe_read();
    t_oe();
    t_forward();
    t_hold_after_write();
    t_desel();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule